// File: doc/BRIEF.md
# Byte-stream destination steering engine

This block takes a byte stream from a decoder and steers every accepted byte to one of five destinations chosen by a 3-bit destination field. Two of the destinations are processors. For these, bytes are packed into a 16-bit host data word, and a data-ready flag holds the stream back until the selected processor reads the word. The other three destinations are memories: a byte-wide sample RAM, a word-wide program RAM and a word-wide shared work RAM. Each memory write leaves through a single registered write port, and an auto-incrementing transfer address advances after each write.

The transfer address has two parts. The programmed part is a register that counts in 8-byte units. Below it sits a 3-bit offset that only the engine can see. The byte address is the register shifted left by 3 with the offset in the low bits. After every memory write the engine writes the new address back into the register, and it keeps the offset to itself. Writing the control field or the address register restarts byte pairing.

The byte input uses valid/ready. A byte is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low while the data-ready flag is set, and also in any cycle that carries a control or address register write. The source must hold its byte and `in_valid` until the byte is taken.

Top module: `xfer_steer`

## Requirements
- R1: After reset, data_ready, end_flag, host_data, the destination field, the address register and the internal offset are all zero, and mem_we is low.
- R2: in_ready is low whenever data_ready is set or ctrl_wr or dma_wr is high, and high otherwise. A byte that is offered while in_ready is low changes no state and produces no memory write.
- R3: An accepted byte for any valid destination goes into host_data[15:8] when offset bit 0 is 0, and into host_data[7:0] when offset bit 0 is 1.
- R4: For destination 2 (main processor) or 3 (sub processor), the byte that completes a word sets data_ready and resets the offset to 0. A pulse on host_rd_main clears data_ready only when the destination is 2, and a pulse on host_rd_sub clears it only when the destination is 3.
- R5: Accepting a byte with in_last high sets end_flag, whatever the destination. end_flag stays set until a control write or reset.
- R6: The byte address is {dma_addr, offset}. The address register is DMA_W bits wide and the offset is 3 bits. After each byte the engine writes the updated address back into dma_addr.
- R7: Destination 4 (sample RAM) issues one byte write for every accepted byte: mem_kind=0, mem_byte=1, mem_addr = byte address mod 8192, and mem_data = {8'h00, byte}. The address then advances by 2, modulo 8192.
- R8: Destination 5 (program RAM) advances the address by 1 on the first byte of a pair and writes nothing. On the second byte it writes {first byte, second byte} with mem_kind=1 and mem_byte=0, at the byte address with bit 0 cleared, and then advances by 1. A carry out of the offset increments dma_addr.
- R9: Destination 7 (work RAM) follows R8 with mem_kind=2. When wram_grant is low the write is suppressed, but the address still advances.
- R10: Destination codes 0, 1 and 6 discard bytes. They leave host_data, data_ready, the address and the offset unchanged and produce no memory write.
- R11: ctrl_wr loads the destination field, clears data_ready and end_flag, and resets the offset to 0. dma_wr loads dma_addr and resets the offset to 0.
- R12: A memory write appears on the port in the cycle after the clock edge that accepted the byte, and lasts for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered by the decoder |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte is the last one of the transfer |
| in_ready | output | 1 | Engine takes the offered byte on this edge |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_dest | input | 3 | Destination code loaded by ctrl_wr |
| dma_wr | input | 1 | Address register write strobe |
| dma_wdata | input | DMA_W | New address register value, in 8-byte units |
| dma_addr | output | DMA_W | Current address register |
| host_rd_main | input | 1 | Main processor read of host_data |
| host_rd_sub | input | 1 | Sub processor read of host_data |
| host_data | output | 16 | Packed host data word |
| data_ready | output | 1 | Word waiting for a processor read |
| end_flag | output | 1 | Last byte of the transfer accepted |
| wram_grant | input | 1 | Work RAM is assigned to this engine |
| mem_we | output | 1 | Memory write strobe |
| mem_kind | output | 2 | Target memory: 0 sample, 1 program, 2 work |
| mem_byte | output | 1 | Write is a single byte on mem_data[7:0] |
| mem_addr | output | DMA_W+3 | Byte address of the write |
| mem_data | output | 16 | Write data |

## Verification
The checker watches several rules on every cycle. A set data_ready always keeps in_ready low. host_data never changes without an accepted byte. data_ready and end_flag only rise after an accepted byte of the right kind, and a control write always clears both. Every work RAM write had the grant present, and every sample write stays below 8 KB, while every word write lands on an even address. Some behaviour only the bench's scenarios can show: the exact byte lanes, address arithmetic across an offset carry or across the sample wrap, the matching between read strobe and destination, and the fact that discard codes leave every visible piece of state unchanged.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  localparam logic [2:0] DEST_MAIN   = 3'd2;
  localparam logic [2:0] DEST_SUB    = 3'd3;
  localparam logic [2:0] DEST_SAMPLE = 3'd4;
  localparam logic [2:0] DEST_PROG   = 3'd5;
  localparam logic [2:0] DEST_WORK   = 3'd7;

  localparam logic [1:0] KIND_SAMPLE = 2'd0;
  localparam logic [1:0] KIND_PROG   = 2'd1;
  localparam logic [1:0] KIND_WORK   = 2'd2;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_PROC,
    CLS_BYTE,
    CLS_WORD
  } dcls_t;
endpackage

// File: rtl/steer_decode.sv
module steer_decode
  import steer_pkg::*;
(
  input  logic [2:0] dest,
  output dcls_t      cls,
  output logic [1:0] kind
);
  always_comb begin
    cls  = CLS_NONE;
    kind = KIND_SAMPLE;
    case (dest)
      DEST_MAIN, DEST_SUB: cls = CLS_PROC;
      DEST_SAMPLE: begin
        cls  = CLS_BYTE;
        kind = KIND_SAMPLE;
      end
      DEST_PROG: begin
        cls  = CLS_WORD;
        kind = KIND_PROG;
      end
      DEST_WORK: begin
        cls  = CLS_WORD;
        kind = KIND_WORK;
      end
      default: cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/steer_addr_unit.sv
module steer_addr_unit
  import steer_pkg::*;
#(
  parameter int DMA_W     = 16,
  parameter int OFF_W     = 3,
  parameter int SAMPLE_AW = 13,
  localparam int ADDR_W   = DMA_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              dma_wr,
  input  logic [DMA_W-1:0]  dma_wdata,
  input  logic              acc,
  input  dcls_t             cls,
  output logic [DMA_W-1:0]  dma_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W-1:0] SMASK =
    {{(ADDR_W-SAMPLE_AW){1'b0}}, {SAMPLE_AW{1'b1}}};

  logic [ADDR_W-1:0] nxt;

  assign cur_addr = {dma_q, off_q};

  always_comb begin
    nxt = cur_addr;
    if (acc) begin
      case (cls)
        CLS_PROC: nxt = off_q[0] ? {dma_q, {OFF_W{1'b0}}}
                                 : (cur_addr | ADDR_W'(1));
        CLS_BYTE: nxt = (cur_addr + ADDR_W'(2)) & SMASK;
        CLS_WORD: nxt = cur_addr + ADDR_W'(1);
        default:  nxt = cur_addr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_q <= '0;
      off_q <= '0;
    end else if (dma_wr) begin
      dma_q <= dma_wdata;
      off_q <= '0;
    end else if (ctrl_wr) begin
      off_q <= '0;
    end else begin
      {dma_q, off_q} <= nxt;
    end
  end
endmodule

// File: rtl/steer_host_reg.sv
module steer_host_reg
  import steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  dcls_t             cls,
  input  logic              lane_lo,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] host_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_q <= '0;
    end else if (acc && cls != CLS_NONE) begin
      if (lane_lo) host_q[BYTE_W-1:0]      <= byte_in;
      else         host_q[WORD_W-1:BYTE_W] <= byte_in;
    end
  end
endmodule

// File: rtl/xfer_steer.sv
module xfer_steer
  import steer_pkg::*;
#(
  parameter int DMA_W     = 16,
  parameter int SAMPLE_AW = 13,
  localparam int OFF_W    = 3,
  localparam int ADDR_W   = DMA_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              ctrl_wr,
  input  logic [2:0]        ctrl_dest,
  input  logic              dma_wr,
  input  logic [DMA_W-1:0]  dma_wdata,
  output logic [DMA_W-1:0]  dma_addr,
  input  logic              host_rd_main,
  input  logic              host_rd_sub,
  output logic [15:0]       host_data,
  output logic              data_ready,
  output logic              end_flag,
  input  logic              wram_grant,
  output logic              mem_we,
  output logic [1:0]        mem_kind,
  output logic              mem_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_data
);
  localparam logic [ADDR_W-1:0] SMASK =
    {{(ADDR_W-SAMPLE_AW){1'b0}}, {SAMPLE_AW{1'b1}}};

  logic [2:0]        dest_q;
  dcls_t             cls;
  logic [1:0]        kind;
  logic              acc;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              rd_hit;
  logic              word_we;

  assign in_ready = !data_ready && !ctrl_wr && !dma_wr;
  assign acc      = in_valid && in_ready;

  steer_decode u_dec (
    .dest (dest_q),
    .cls  (cls),
    .kind (kind)
  );

  steer_addr_unit #(
    .DMA_W     (DMA_W),
    .OFF_W     (OFF_W),
    .SAMPLE_AW (SAMPLE_AW)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .dma_wr    (dma_wr),
    .dma_wdata (dma_wdata),
    .acc       (acc),
    .cls       (cls),
    .dma_q     (dma_addr),
    .off_q     (off_q),
    .cur_addr  (cur_addr)
  );

  steer_host_reg u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .cls     (cls),
    .lane_lo (off_q[0]),
    .byte_in (in_data),
    .host_q  (host_data)
  );

  assign rd_hit = (host_rd_main && dest_q == DEST_MAIN) ||
                  (host_rd_sub  && dest_q == DEST_SUB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q     <= '0;
      data_ready <= 1'b0;
      end_flag   <= 1'b0;
    end else if (ctrl_wr) begin
      dest_q     <= ctrl_dest;
      data_ready <= 1'b0;
      end_flag   <= 1'b0;
    end else begin
      if (acc && cls == CLS_PROC && off_q[0]) data_ready <= 1'b1;
      else if (data_ready && rd_hit)          data_ready <= 1'b0;
      if (acc && in_last) end_flag <= 1'b1;
    end
  end

  assign word_we = (cls == CLS_WORD) && off_q[0] &&
                   (kind != KIND_WORK || wram_grant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_kind <= '0;
      mem_byte <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= acc && (cls == CLS_BYTE || word_we);
      if (acc) begin
        mem_kind <= kind;
        mem_byte <= (cls == CLS_BYTE);
        if (cls == CLS_BYTE) begin
          mem_addr <= cur_addr & SMASK;
          mem_data <= {8'h00, in_data};
        end else begin
          mem_addr <= {cur_addr[ADDR_W-1:1], 1'b0};
          mem_data <= {host_data[15:8], in_data};
        end
      end
    end
  end
endmodule

// File: rtl/xfer_steer_chk.sv
module xfer_steer_chk #(
  parameter int ADDR_W    = 19,
  parameter int SAMPLE_AW = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic              ctrl_wr,
  input logic              wram_grant,
  input logic              data_ready,
  input logic              end_flag,
  input logic [15:0]       host_data,
  input logic              mem_we,
  input logic [1:0]        mem_kind,
  input logic              mem_byte,
  input logic [ADDR_W-1:0] mem_addr
);
  // R2
  stall_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> !in_ready);

  // R2
  host_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(host_data));

  // R4
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(in_valid && in_ready));

  // R5
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(in_valid && in_ready && in_last));

  // R11
  ctrl_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_wr) |-> (!data_ready && !end_flag));

  // R9
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_kind == 2'd2) |-> $past(wram_grant));

  // R7
  sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_byte) |-> ((mem_addr >> SAMPLE_AW) == '0));

  // R8
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_byte) |-> !mem_addr[0]);
endmodule

bind xfer_steer xfer_steer_chk #(
  .ADDR_W    (ADDR_W),
  .SAMPLE_AW (SAMPLE_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .in_ready   (in_ready),
  .ctrl_wr    (ctrl_wr),
  .wram_grant (wram_grant),
  .data_ready (data_ready),
  .end_flag   (end_flag),
  .host_data  (host_data),
  .mem_we     (mem_we),
  .mem_kind   (mem_kind),
  .mem_byte   (mem_byte),
  .mem_addr   (mem_addr)
);

// File: tb/sim_xfer_steer.sv
`timescale 1ns/1ps
module sim_xfer_steer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_data;
  logic        ctrl_wr, dma_wr, host_rd_main, host_rd_sub, wram_grant;
  logic [2:0]  ctrl_dest;
  logic [15:0] dma_wdata, dma_addr, host_data, mem_data;
  logic        data_ready, end_flag, mem_we, mem_byte;
  logic [1:0]  mem_kind;
  logic [18:0] mem_addr;

  xfer_steer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .ctrl_wr(ctrl_wr),
    .ctrl_dest(ctrl_dest), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .dma_addr(dma_addr), .host_rd_main(host_rd_main),
    .host_rd_sub(host_rd_sub), .host_data(host_data),
    .data_ready(data_ready), .end_flag(end_flag), .wram_grant(wram_grant),
    .mem_we(mem_we), .mem_kind(mem_kind), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_reg, m_host;
  logic [2:0]  m_off, m_dest;
  logic        m_dr, m_end;
  logic        e_we, e_byte;
  logic [1:0]  e_kind;
  logic [18:0] e_addr;
  logic [15:0] e_data;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mem_tag(input logic [2:0] d);
    case (d)
      3'd4: return "R7 sample write";
      3'd5: return "R8 program write";
      3'd7: return "R9 work write";
      default: return "R10 discard/no write";
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 0; in_data = '0; in_last = 0; ctrl_wr = 0; ctrl_dest = '0;
    dma_wr = 0; dma_wdata = '0; host_rd_main = 0; host_rd_sub = 0;
  endtask

  task automatic check_state();
    chk("R3 host_data", {16'h0, host_data}, {16'h0, m_host});
    chk("R4 data_ready", {31'h0, data_ready}, {31'h0, m_dr});
    chk("R5 end_flag", {31'h0, end_flag}, {31'h0, m_end});
    chk("R6 dma_addr", {16'h0, dma_addr}, {16'h0, m_reg});
    chk({"R12 mem_we ", mem_tag(m_dest)}, {31'h0, mem_we}, {31'h0, e_we});
    if (e_we && mem_we) begin
      chk({"R6 mem_addr ", mem_tag(m_dest)}, {13'h0, mem_addr}, {13'h0, e_addr});
      chk({"R8 mem_data ", mem_tag(m_dest)}, {16'h0, mem_data}, {16'h0, e_data});
      chk("R7 mem_kind", {30'h0, mem_kind}, {30'h0, e_kind});
      chk("R7 mem_byte", {31'h0, mem_byte}, {31'h0, e_byte});
    end
  endtask

  task automatic model_byte(input logic [7:0] b, input logic last);
    logic [18:0] a;
    a = {m_reg, m_off};
    case (m_dest)
      3'd2, 3'd3: begin
        if (!m_off[0]) begin m_host[15:8] = b; m_off[0] = 1'b1; end
        else begin m_host[7:0] = b; m_off = '0; m_dr = 1'b1; end
      end
      3'd4: begin
        if (!m_off[0]) m_host[15:8] = b; else m_host[7:0] = b;
        e_we = 1; e_kind = 2'd0; e_byte = 1;
        e_addr = a & 19'h1FFF; e_data = {8'h00, b};
        {m_reg, m_off} = (a + 19'd2) & 19'h1FFF;
      end
      3'd5, 3'd7: begin
        if (!m_off[0]) m_host[15:8] = b;
        else begin
          m_host[7:0] = b;
          e_we = (m_dest == 3'd5) || wram_grant;
          e_kind = (m_dest == 3'd5) ? 2'd1 : 2'd2; e_byte = 0;
          e_addr = {a[18:1], 1'b0}; e_data = m_host;
        end
        {m_reg, m_off} = a + 19'd1;
      end
      default: ;
    endcase
    if (last) m_end = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, input logic last);
    in_valid = 1; in_data = b; in_last = last;
    #1;
    chk("R2 in_ready", {31'h0, in_ready}, {31'h0, !m_dr});
    e_we = 0;
    if (!m_dr) model_byte(b, last);
    tick();
    in_valid = 0; in_last = 0;
    check_state();
  endtask

  task automatic wr_ctrl(input logic [2:0] d);
    ctrl_wr = 1; ctrl_dest = d; in_valid = 1; in_data = 8'hEE;
    #1;
    chk("R2 in_ready during ctrl write", {31'h0, in_ready}, 32'h0);
    tick();
    idle();
    m_dest = d; m_dr = 0; m_end = 0; m_off = '0; e_we = 0;
    check_state();
  endtask

  task automatic wr_dma(input logic [15:0] v);
    dma_wr = 1; dma_wdata = v;
    tick();
    idle();
    m_reg = v; m_off = '0; e_we = 0;
    check_state();
  endtask

  task automatic rd(input bit main);
    if (main) host_rd_main = 1; else host_rd_sub = 1;
    tick();
    idle();
    if (m_dr && ((main && m_dest == 3'd2) || (!main && m_dest == 3'd3))) m_dr = 0;
    e_we = 0;
    check_state();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    wram_grant = 1;
    rst_n = 0;
    m_reg = '0; m_host = '0; m_off = '0; m_dest = '0; m_dr = 0; m_end = 0;
    e_we = 0; e_kind = '0; e_byte = 0; e_addr = '0; e_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset host_data", {16'h0, host_data}, 32'h0);
    chk("R1 reset flags", {30'h0, data_ready, end_flag}, 32'h0);
    chk("R1 reset dma_addr/mem_we", {15'h0, mem_we, dma_addr}, 32'h0);
    // R10 discard at reset destination 0
    send(8'hA5, 1'b0);

    // R4 main processor handshake, wrong strobe first
    wr_ctrl(3'd2);
    send(8'h12, 1'b0); send(8'h34, 1'b0);
    send(8'h56, 1'b0);           // refused while full (R2)
    rd(1'b0);                    // sub strobe: no effect (R4)
    rd(1'b1);                    // clears (R4)
    send(8'h56, 1'b1);           // R5 end flag
    wr_ctrl(3'd3);
    send(8'h9A, 1'b0); send(8'hBC, 1'b0);
    rd(1'b1); rd(1'b0);

    // R7 sample wrap across 8 KB
    wr_ctrl(3'd4);
    wr_dma(16'h03FF);
    for (int i = 0; i < 6; i++) send(8'(8'h40 + i), 1'b0);

    // R8 program RAM with offset carry
    wr_ctrl(3'd5);
    wr_dma(16'h0012);
    for (int i = 0; i < 10; i++) send(8'(8'h80 + i), 1'b0);

    // R9 work RAM with grant low then high
    wr_ctrl(3'd7);
    wram_grant = 0;
    for (int i = 0; i < 4; i++) send(8'(8'hC0 + i), 1'b0);
    wram_grant = 1;
    for (int i = 0; i < 4; i++) send(8'(8'hD0 + i), 1'b0);

    // R10 discard codes, R11 dma write restarts pairing
    wr_ctrl(3'd6); send(8'h11, 1'b0); send(8'h22, 1'b1);
    wr_ctrl(3'd1); send(8'h33, 1'b0);
    wr_ctrl(3'd5); send(8'h44, 1'b0); wr_dma(16'h0100); send(8'h55, 1'b0); send(8'h66, 1'b0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r == 0)      wr_ctrl(3'($urandom % 8));
      else if (r == 1) wr_dma(16'($urandom % 2048));
      else if (r == 2) rd(1'b1);
      else if (r == 3) rd(1'b0);
      else if (r == 4) wram_grant = ~wram_grant;
      else             send(8'($urandom), ($urandom % 8) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule